// File: doc/BRIEF.md
# Per-Block Lock Protection Controller

This block holds the protection state of every erase block in a flash array and rules on whether a program or erase aimed at a block may proceed. Software changes the state with a two-write sequence on the command bus. The first write is a setup code naming the block. The second write is a confirm code that locks, unlocks or locks down that block. The new state takes effect at once, with no busy period.

A block that is locked down can be freed only while the write-protect input is high, and only reset clears its lock-down flag. The array sequencer asks about a block through a request port and gets a grant or a protection-violation pulse one cycle later. An identifier read mode returns the lock and lock-down flags of any block. The block count is a parameter, and every block starts locked.

Top module: `lock_guard`

## Requirements
- R1: While and after reset, every block reads locked and not locked-down, identifier mode is off (`idData` = 0), and `seqErr`, `opGrant` and `opDenied` are low.
- R2: A write of 0x60 to block B followed by a write of 0x01 to block B sets B's lock flag.
- R3: A write of 0x60 to block B followed by a write of 0xD0 to block B clears B's lock flag, except as limited by R6.
- R4: A write of 0x60 followed by 0x2F to the same block sets both its lock and lock-down flags. No command clears a lock-down flag; only reset does.
- R5: In the cycle after `opReq` is high with `opBlk` = B, exactly one of `opGrant` (B unlocked) or `opDenied` (B locked) pulses high. With no request both stay low.
- R6: While `wpN` is low, an unlock confirm aimed at a locked-down block has no effect. While `wpN` is high, the same confirm clears the lock flag and the lock-down flag remains set.
- R7: A confirm write whose code is none of 0x01, 0xD0 or 0x2F pulses `seqErr` for the one cycle after that write. It leaves all flags unchanged and ends the sequence.
- R8: A confirm write to a block other than the one named at setup pulses `seqErr` in the same way and changes no flag.
- R9: A write of 0x90 outside a sequence enters identifier mode, where `idData` = {lock-down, lock} of block `rdBlk` (bit 1 is lock-down, bit 0 is lock). A write of 0xFF leaves the mode, and `idData` is then 0. Other writes outside a sequence are ignored.
- R10: A lock-state change is visible at `idData` and at the request port from the first clock edge after the confirm write, with no busy interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Command bus write strobe |
| wrBlk | input | BLK_W | Block index addressed by the write |
| wrData | input | 8 | Command code byte |
| wpN | input | 1 | Write-protect input; low keeps locked-down blocks locked |
| opReq | input | 1 | Program/erase permission request |
| opBlk | input | BLK_W | Block targeted by the request |
| opGrant | output | 1 | Request allowed (one-cycle pulse) |
| opDenied | output | 1 | Block-lock violation (one-cycle pulse) |
| seqErr | output | 1 | Command sequence error (one-cycle pulse) |
| rdBlk | input | BLK_W | Block selected for identifier readback |
| idData | output | 2 | {lock-down, lock} of rdBlk in identifier mode, else 0 |

## Verification
The hardest case to reach is a locked-down block that has been unlocked while `wpN` was high. `wpN` then drops, and a later unlock is refused while lock and unlock commands are still aimed at neighbouring blocks. Random sequences toggle `wpN`, mix all confirm codes, bad codes and mismatched confirm blocks over a small block count, and request permission at random. Directed steps pin this corner down explicitly and compare full identifier readbacks against a bench model.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;
  localparam logic [7:0] CMD_SETUP  = 8'h60;
  localparam logic [7:0] CMD_LOCK   = 8'h01;
  localparam logic [7:0] CMD_UNLOCK = 8'hD0;
  localparam logic [7:0] CMD_DOWN   = 8'h2F;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_ARRAY  = 8'hFF;

  typedef struct packed {
    logic setLock;
    logic clrLock;
    logic setDown;
  } lockStrobe_t;
endpackage

// File: rtl/lock_guard_ctrl.sv
module lock_guard_ctrl
  import lock_guard_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [BLK_W-1:0] wrBlk,
  input  logic [7:0]       wrData,
  output lockStrobe_t      strobe,
  output logic [BLK_W-1:0] strobeBlk,
  output logic             idMode,
  output logic             seqErr
);
  logic             pendQ;
  logic [BLK_W-1:0] pendBlkQ;
  logic             confirmCyc;
  logic             sameBlk;
  logic             codeOk;
  logic             badConfirm;

  assign confirmCyc = wrEn && pendQ;
  assign sameBlk    = (wrBlk == pendBlkQ);
  assign codeOk     = (wrData == CMD_LOCK) || (wrData == CMD_UNLOCK) || (wrData == CMD_DOWN);
  assign badConfirm = confirmCyc && !(sameBlk && codeOk);

  always_comb begin
    strobe = '0;
    if (confirmCyc && sameBlk) begin
      strobe.setLock = (wrData == CMD_LOCK) || (wrData == CMD_DOWN);
      strobe.clrLock = (wrData == CMD_UNLOCK);
      strobe.setDown = (wrData == CMD_DOWN);
    end
  end

  assign strobeBlk = pendBlkQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= 1'b0;
      pendBlkQ <= '0;
      idMode   <= 1'b0;
      seqErr   <= 1'b0;
    end else begin
      seqErr <= badConfirm;
      if (wrEn) begin
        if (pendQ) begin
          pendQ <= 1'b0;
        end else if (wrData == CMD_SETUP) begin
          pendQ    <= 1'b1;
          pendBlkQ <= wrBlk;
        end else if (wrData == CMD_IDENT) begin
          idMode <= 1'b1;
        end else if (wrData == CMD_ARRAY) begin
          idMode <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lock_guard_store.sv
module lock_guard_store
  import lock_guard_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int BLK_W      = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lockStrobe_t           strobe,
  input  logic [BLK_W-1:0]      strobeBlk,
  input  logic                  wpN,
  input  logic                  idMode,
  input  logic                  opReq,
  input  logic [BLK_W-1:0]      opBlk,
  input  logic [BLK_W-1:0]      rdBlk,
  output logic                  opGrant,
  output logic                  opDenied,
  output logic [1:0]            idData,
  output logic [NUM_BLOCKS-1:0] lockVec,
  output logic [NUM_BLOCKS-1:0] downVec
);
  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
    logic hit;
    logic freeOk;
    assign hit    = (strobeBlk == BLK_W'(i));
    assign freeOk = !(downVec[i] && !wpN);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lockVec[i] <= 1'b1;
        downVec[i] <= 1'b0;
      end else if (hit) begin
        if (strobe.setLock) lockVec[i] <= 1'b1;
        else if (strobe.clrLock && freeOk) lockVec[i] <= 1'b0;
        if (strobe.setDown) downVec[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opGrant  <= 1'b0;
      opDenied <= 1'b0;
    end else begin
      opGrant  <= opReq && !lockVec[opBlk];
      opDenied <= opReq && lockVec[opBlk];
    end
  end

  assign idData = idMode ? {downVec[rdBlk], lockVec[rdBlk]} : 2'b00;
endmodule

// File: rtl/lock_guard.sv
module lock_guard
  import lock_guard_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [BLK_W-1:0] wrBlk,
  input  logic [7:0]       wrData,
  input  logic             wpN,
  input  logic             opReq,
  input  logic [BLK_W-1:0] opBlk,
  output logic             opGrant,
  output logic             opDenied,
  output logic             seqErr,
  input  logic [BLK_W-1:0] rdBlk,
  output logic [1:0]       idData
);
  lockStrobe_t           strobe;
  logic [BLK_W-1:0]      strobeBlk;
  logic                  idMode;
  logic [NUM_BLOCKS-1:0] lockVec;
  logic [NUM_BLOCKS-1:0] downVec;

  lock_guard_ctrl #(.BLK_W(BLK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBlk(wrBlk), .wrData(wrData),
    .strobe(strobe), .strobeBlk(strobeBlk), .idMode(idMode), .seqErr(seqErr)
  );

  lock_guard_store #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .strobeBlk(strobeBlk), .wpN(wpN),
    .idMode(idMode), .opReq(opReq), .opBlk(opBlk), .rdBlk(rdBlk),
    .opGrant(opGrant), .opDenied(opDenied), .idData(idData),
    .lockVec(lockVec), .downVec(downVec)
  );
endmodule

// File: rtl/lock_guard_checker.sv
module lock_guard_checker #(
  parameter int NUM_BLOCKS = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wpN,
  input logic                  opReq,
  input logic                  opGrant,
  input logic                  opDenied,
  input logic                  seqErr,
  input logic [NUM_BLOCKS-1:0] lockVec,
  input logic [NUM_BLOCKS-1:0] downVec
);
  // R5: never both answers at once
  p_one_answer_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(opGrant && opDenied));

  // R5: an answer only follows a request
  p_answer_needs_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opGrant || opDenied) |-> $past(opReq));

  // R4: lock-down flags never fall outside reset
  p_down_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(downVec) & ~downVec) == '0));

  // R6: with write-protect low, locked-down locked blocks stay locked
  p_wp_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wpN |=> (($past(downVec & lockVec) & ~lockVec) == '0));

  // R7: a sequence error leaves every flag as it was
  p_seq_no_change_r7: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |-> ($stable(lockVec) && $stable(downVec)));
endmodule

bind lock_guard lock_guard_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_checker (
  .clk(clk), .rstN(rstN), .wpN(wpN), .opReq(opReq), .opGrant(opGrant),
  .opDenied(opDenied), .seqErr(seqErr), .lockVec(lockVec), .downVec(downVec)
);

// File: tb/lock_guard_bench.sv
module lock_guard_bench;
  localparam int NB = 8;
  localparam int BW = $clog2(NB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [BW-1:0] wrBlk = '0;
  logic [7:0] wrData = '0;
  logic wpN = 1'b0;
  logic opReq = 1'b0;
  logic [BW-1:0] opBlk = '0;
  logic [BW-1:0] rdBlk = '0;
  logic opGrant, opDenied, seqErr;
  logic [1:0] idData;

  int checks = 0;
  int errors = 0;
  bit mLock [NB];
  bit mDown [NB];
  bit mId;

  always #5 clk = ~clk;

  lock_guard #(.NUM_BLOCKS(NB)) u_lock_guard (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBlk(wrBlk), .wrData(wrData),
    .wpN(wpN), .opReq(opReq), .opBlk(opBlk), .opGrant(opGrant),
    .opDenied(opDenied), .seqErr(seqErr), .rdBlk(rdBlk), .idData(idData)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit codeValid(input logic [7:0] c);
    return c == 8'h01 || c == 8'hD0 || c == 8'h2F;
  endfunction

  task automatic busWrite(input logic [BW-1:0] b, input logic [7:0] d, output bit err);
    @(negedge clk);
    wrEn = 1'b1; wrBlk = b; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    err = seqErr;
  endtask

  // two-write sequence; model applied from the requirements
  task automatic lockSeq(input logic [BW-1:0] b, input logic [BW-1:0] cb, input logic [7:0] code);
    bit err;
    bit expErr;
    busWrite(b, 8'h60, err);
    check("R7 setup no error", int'(err), 0);
    busWrite(cb, code, err);
    expErr = !(cb == b && codeValid(code));
    check(cb != b ? "R8 wrong block seqErr" : "R7 code seqErr", int'(err), int'(expErr));
    if (!expErr) begin
      if (code == 8'h01) mLock[b] = 1'b1;                         // R2
      else if (code == 8'h2F) begin mLock[b] = 1'b1; mDown[b] = 1'b1; end // R4
      else if (!(mDown[b] && !wpN)) mLock[b] = 1'b0;              // R3 R6
    end
  endtask

  task automatic setId(input bit on);
    bit err;
    busWrite(0, on ? 8'h90 : 8'hFF, err);
    mId = on;
  endtask

  task automatic readAll(input string req);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      rdBlk = BW'(i);
      #1;
      check(req, int'(idData), mId ? int'({mDown[i], mLock[i]}) : 0);
    end
  endtask

  task automatic askOp(input logic [BW-1:0] b);
    @(negedge clk);
    opReq = 1'b1; opBlk = b;
    @(negedge clk);
    opReq = 1'b0;
    check("R5 grant", int'(opGrant), int'(!mLock[b]));
    check("R5 denied", int'(opDenied), int'(mLock[b]));
    @(negedge clk);
    check("R5 idle answer", int'(opGrant | opDenied), 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit err;
    logic [7:0] codes [5];
    codes[0] = 8'h01; codes[1] = 8'hD0; codes[2] = 8'h2F; codes[3] = 8'h60; codes[4] = 8'h55;
    void'($urandom(32'd4711));
    for (int i = 0; i < NB; i++) begin mLock[i] = 1'b1; mDown[i] = 1'b0; end
    mId = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 idData off", int'(idData), 0);
    check("R1 seqErr", int'(seqErr), 0);
    check("R1 outputs", int'(opGrant | opDenied), 0);
    askOp(3);
    setId(1'b1);
    readAll("R1 all locked");

    // R3 R10 directed unlock then immediate use
    wpN = 1'b1;
    lockSeq(2, 2, 8'hD0);
    rdBlk = 2; #1;
    check("R10 visible after confirm", int'(idData), 0);
    askOp(2);
    // R2 relock
    lockSeq(2, 2, 8'h01);
    askOp(2);
    // R4 R6: lock down, unlock with WP high, then WP low refuses
    lockSeq(5, 5, 8'h2F);
    lockSeq(5, 5, 8'hD0);
    readAll("R6 wp high unlock keeps down");
    lockSeq(5, 5, 8'h01);
    wpN = 1'b0;
    lockSeq(5, 5, 8'hD0);
    readAll("R6 wp low refuses unlock");
    askOp(5);
    // R7 bad code, R8 wrong block
    lockSeq(1, 1, 8'h33);
    lockSeq(1, 4, 8'hD0);
    readAll("R7 R8 no change");
    // R9 exit id mode and ignored writes
    setId(1'b0);
    busWrite(0, 8'h40, err);
    check("R9 ignored write no error", int'(err), 0);
    readAll("R9 id mode off");
    setId(1'b1);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int sel;
      logic [BW-1:0] b;
      sel = int'($urandom % 6);
      b = BW'($urandom % NB);
      case (sel)
        0, 1: lockSeq(b, b, codes[$urandom % 5]);
        2: lockSeq(b, ($urandom % 4 == 0) ? BW'(b + 1) : b, codes[$urandom % 3]);
        3: wpN = ~wpN;
        4: askOp(b);
        default: readAll("R9 random readback");
      endcase
    end
    readAll("R4 R6 final readback");

    // R1 R4 reset clears lock-down
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < NB; i++) begin mLock[i] = 1'b1; mDown[i] = 1'b0; end
    mId = 1'b0;
    readAll("R1 after reset id off");
    setId(1'b1);
    readAll("R4 reset clears down");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule